// File: doc/BRIEF.md
# Status Register with Data Breakpoint

This block holds a small processor status word and a debug address register, and it watches the data access stream for a breakpoint hit. The status word has four fields. The condition code is set by execution units from an instruction's result and tested by conditional branches. The loop condition code is set and tested by a single loop instruction. The other two fields are break-on-read and break-on-write enables.

Software writes the status word through a write port. The two breakpoint enables are protected fields, and they change only while the supervisor-mode flag is high. A user-mode write updates only the condition code bits.

A separate comparator checks each valid data access against the debug address. It raises a trap pulse in the cycle of the access when the two addresses are equal and the breakpoint for that access direction is enabled. The trap is used by the surrounding trap logic. Trap vectoring is not part of this block.

Top module: `stat_brk_reg`

## Requirements
- R1: After reset, every status bit reads 0 and the debug address holds 0.
- R2: The status word layout is bit 0 for the condition code, bit 1 for the loop condition code, bit 2 for the break-on-read enable and bit 3 for the break-on-write enable.
- R3: A status write with `sup_mode` high loads all four bits from `sw_wr_data` on the next clock edge.
- R4: A status write with `sup_mode` low loads bits 1:0 from `sw_wr_data`; bits 3:2 keep their values.
- R5: A pulse on `cc_upd` loads `cc_val` into bit 0, and a pulse on `lcc_upd` loads `lcc_val` into bit 1, on the next clock edge.
- R6: When a status write and a condition code strobe hit the same cycle, the written data takes the bit; strobes only act on bits the write leaves unchanged (protected bits in user mode have no strobe).
- R7: A valid read access (`acc_is_write` = 0) whose 32-bit address equals the debug address raises `brk_trap` in that same cycle when bit 2 is set.
- R8: A valid write access (`acc_is_write` = 1) whose address equals the debug address raises `brk_trap` in that same cycle when bit 3 is set.
- R9: `brk_trap` stays low in any of these cases: `acc_valid` is low, the address differs in any bit, or the enable for that access direction is clear.
- R10: A write to the debug address takes effect on the next clock edge. An access in the same cycle as the write is compared against the old address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Status word write strobe |
| sw_wr_data | input | 4 | Status word write data |
| sup_mode | input | 1 | High while the processor is in supervisor mode |
| cc_upd | input | 1 | Condition code update strobe |
| cc_val | input | 1 | Condition code value |
| lcc_upd | input | 1 | Loop condition code update strobe |
| lcc_val | input | 1 | Loop condition code value |
| dbg_wr_en | input | 1 | Debug address write strobe |
| dbg_wr_data | input | 32 | Debug address write data |
| acc_valid | input | 1 | A data access is present this cycle |
| acc_addr | input | 32 | Operand address of the access |
| acc_is_write | input | 1 | 1 for a write access, 0 for a read access |
| stat_q | output | 4 | Current status word |
| brk_trap | output | 1 | Data breakpoint trap pulse |

## Verification
The comparator is tried with several access patterns against one debug address:
- an exact match in each direction,
- addresses that differ only in the lowest bit or only in the highest bit,
- an exact match with `acc_valid` low,
- a match while only one direction is enabled.

Together these separate a full-width equality check from a partial one, and a direction-qualified check from an unqualified one.

Status writes are applied in both privilege modes, and also with update strobes in the same cycle. This shows that protection masks only bits 3:2 and that the written data takes precedence over a strobe. A debug address write made in the same cycle as an access shows when the new address takes effect.

// File: rtl/stat_brk_pkg.sv
package stat_brk_pkg;
   localparam int STAT_W  = 4;
   localparam int CC_BIT  = 0;
   localparam int LCC_BIT = 1;
   localparam int BRD_BIT = 2;
   localparam int BWR_BIT = 3;
   localparam logic [STAT_W-1:0] PROT_DEFAULT = 4'b1100;
endpackage

// File: rtl/stat_fields.sv
module stat_fields
   import stat_brk_pkg::*;
#(
   parameter logic [STAT_W-1:0] PROT_MASK = PROT_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wr_data,
   input  logic              sup_mode,
   input  logic              cc_upd,
   input  logic              cc_val,
   input  logic              lcc_upd,
   input  logic              lcc_val,
   output logic [STAT_W-1:0] stat_q
);
   logic [STAT_W-1:0] hw_upd;
   logic [STAT_W-1:0] hw_val;

   always_comb begin
      hw_upd          = '0;
      hw_val          = '0;
      hw_upd[CC_BIT]  = cc_upd;
      hw_val[CC_BIT]  = cc_val;
      hw_upd[LCC_BIT] = lcc_upd;
      hw_val[LCC_BIT] = lcc_val;
   end

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      logic sw_ok;
      if (PROT_MASK[i]) begin : g_prot
         assign sw_ok = wr_en & sup_mode;
      end else begin : g_open
         assign sw_ok = wr_en;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          stat_q[i] <= 1'b0;
         else if (sw_ok)      stat_q[i] <= wr_data[i];
         else if (hw_upd[i])  stat_q[i] <= hw_val[i];
      end
   end
endmodule

// File: rtl/dbg_addr_reg.sv
module dbg_addr_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] addr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr_q <= '0;
      else if (wr_en) addr_q <= wr_data;
   end
endmodule

// File: rtl/brk_match.sv
module brk_match #(
   parameter int ADDR_W = 32
) (
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_is_write,
   input  logic [ADDR_W-1:0] dbg_addr,
   input  logic              rd_en,
   input  logic              wr_en,
   output logic              trap
);
   logic hit;
   logic dir_ok;

   assign hit    = (acc_addr == dbg_addr);
   assign dir_ok = acc_is_write ? wr_en : rd_en;
   assign trap   = acc_valid & hit & dir_ok;
endmodule

// File: rtl/stat_brk_reg.sv
module stat_brk_reg
   import stat_brk_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter logic [STAT_W-1:0] PROT_MASK = PROT_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr_en,
   input  logic [STAT_W-1:0] sw_wr_data,
   input  logic              sup_mode,
   input  logic              cc_upd,
   input  logic              cc_val,
   input  logic              lcc_upd,
   input  logic              lcc_val,
   input  logic              dbg_wr_en,
   input  logic [ADDR_W-1:0] dbg_wr_data,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_is_write,
   output logic [STAT_W-1:0] stat_q,
   output logic              brk_trap
);
   if (ADDR_W < 1) begin : g_bad_width
      $error("stat_brk_reg: ADDR_W must be positive");
   end

   logic [ADDR_W-1:0] dbg_q;

   stat_fields #(.PROT_MASK(PROT_MASK)) u_fields (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sw_wr_en),
      .wr_data  (sw_wr_data),
      .sup_mode (sup_mode),
      .cc_upd   (cc_upd),
      .cc_val   (cc_val),
      .lcc_upd  (lcc_upd),
      .lcc_val  (lcc_val),
      .stat_q   (stat_q)
   );

   dbg_addr_reg #(.ADDR_W(ADDR_W)) u_dbg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dbg_wr_en),
      .wr_data (dbg_wr_data),
      .addr_q  (dbg_q)
   );

   brk_match #(.ADDR_W(ADDR_W)) u_match (
      .acc_valid    (acc_valid),
      .acc_addr     (acc_addr),
      .acc_is_write (acc_is_write),
      .dbg_addr     (dbg_q),
      .rd_en        (stat_q[BRD_BIT]),
      .wr_en        (stat_q[BWR_BIT]),
      .trap         (brk_trap)
   );
endmodule

// File: rtl/stat_brk_chk.sv
module stat_brk_chk
   import stat_brk_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter logic [STAT_W-1:0] PROT_MASK = PROT_DEFAULT
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_wr_en,
   input logic [STAT_W-1:0] sw_wr_data,
   input logic              sup_mode,
   input logic              cc_upd,
   input logic              cc_val,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_is_write,
   input logic [ADDR_W-1:0] dbg_addr,
   input logic [STAT_W-1:0] stat_q,
   input logic              brk_trap
);
   AST_RD_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_is_write && acc_addr == dbg_addr && stat_q[BRD_BIT]) |-> brk_trap); // R7
   AST_WR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_is_write && acc_addr == dbg_addr && stat_q[BWR_BIT]) |-> brk_trap); // R8
   AST_NO_FALSE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      brk_trap |-> (acc_valid && acc_addr == dbg_addr)); // R9
   AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_en && !sup_mode) |=> ((stat_q & PROT_MASK) == ($past(stat_q) & PROT_MASK))); // R4
   AST_SUP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_en && sup_mode) |=> (stat_q == $past(sw_wr_data))); // R3
   AST_CC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_upd && !sw_wr_en) |=> (stat_q[CC_BIT] == $past(cc_val))); // R5
endmodule

bind stat_brk_reg stat_brk_chk #(.ADDR_W(ADDR_W), .PROT_MASK(PROT_MASK)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sw_wr_en     (sw_wr_en),
   .sw_wr_data   (sw_wr_data),
   .sup_mode     (sup_mode),
   .cc_upd       (cc_upd),
   .cc_val       (cc_val),
   .acc_valid    (acc_valid),
   .acc_addr     (acc_addr),
   .acc_is_write (acc_is_write),
   .dbg_addr     (dbg_q),
   .stat_q       (stat_q),
   .brk_trap     (brk_trap)
);

// File: tb/tb_stat_brk_reg.sv
module tb_stat_brk_reg;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] DA = 32'hA5A5_0F00;
   localparam logic [31:0] DB = 32'h0000_1234;
   // {expected trap, is_write, valid, address}
   localparam logic [34:0] VEC [6] = '{
      {1'b1, 1'b0, 1'b1, DA},
      {1'b1, 1'b1, 1'b1, DA},
      {1'b0, 1'b0, 1'b1, DA ^ 32'h0000_0001},
      {1'b0, 1'b1, 1'b1, DA ^ 32'h8000_0000},
      {1'b0, 1'b0, 1'b0, DA},
      {1'b0, 1'b0, 1'b1, 32'h0000_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sw_wr_en, sup_mode, cc_upd, cc_val, lcc_upd, lcc_val;
   logic [3:0]  sw_wr_data;
   logic        dbg_wr_en, acc_valid, acc_is_write;
   logic [31:0] dbg_wr_data, acc_addr;
   logic [3:0]  stat_q;
   logic        brk_trap;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   stat_brk_reg dut (
      .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
      .sup_mode(sup_mode), .cc_upd(cc_upd), .cc_val(cc_val), .lcc_upd(lcc_upd),
      .lcc_val(lcc_val), .dbg_wr_en(dbg_wr_en), .dbg_wr_data(dbg_wr_data),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_is_write(acc_is_write),
      .stat_q(stat_q), .brk_trap(brk_trap)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      sw_wr_en = 0; cc_upd = 0; lcc_upd = 0; dbg_wr_en = 0; acc_valid = 0;
   endtask

   task automatic swr(input logic sup, input logic [3:0] d);
      sw_wr_en = 1; sup_mode = sup; sw_wr_data = d;
      tick();
      idle();
   endtask

   task automatic acc(input logic [31:0] a, input logic w);
      acc_valid = 1; acc_addr = a; acc_is_write = w; #1;
   endtask

   initial begin
      rst_n = 0; idle(); sup_mode = 0; sw_wr_data = 0; cc_val = 0; lcc_val = 0;
      dbg_wr_data = 0; acc_addr = 0; acc_is_write = 0;
      repeat (3) @(negedge clk);
      chk("R1 status cleared in reset", {28'd0, stat_q}, 32'd0);
      rst_n = 1;
      tick();
      chk("R1 status after reset", {28'd0, stat_q}, 32'd0);
      swr(1'b1, 4'b1100);
      acc(32'd0, 1'b0);
      chk("R1 debug address reset to zero", {31'd0, brk_trap}, 32'd1);
      idle();
      dbg_wr_en = 1; dbg_wr_data = DA;
      tick();
      idle();
      for (int i = 0; i < 6; i++) begin
         acc_addr = VEC[i][31:0]; acc_valid = VEC[i][32]; acc_is_write = VEC[i][33]; #1;
         chk("R7_R8_R9 trap vector", {31'd0, brk_trap}, {31'd0, VEC[i][34]});
         tick();
      end
      idle();
      swr(1'b1, 4'b0100);
      acc(DA, 1'b1);
      chk("R9 write hit with only read enabled", {31'd0, brk_trap}, 32'd0);
      acc(DA, 1'b0);
      chk("R7 read hit with only read enabled", {31'd0, brk_trap}, 32'd1);
      idle();
      swr(1'b0, 4'b1011);
      chk("R4 user write keeps protected bits", {28'd0, stat_q}, 32'h7);
      acc(DA, 1'b1);
      chk("R4 user write did not enable write break", {31'd0, brk_trap}, 32'd0);
      idle();
      swr(1'b1, 4'b1000);
      chk("R3 supervisor write loads all bits", {28'd0, stat_q}, 32'h8);
      cc_upd = 1; cc_val = 1;
      tick(); idle();
      chk("R2 R5 condition code is bit 0", {28'd0, stat_q}, 32'h9);
      lcc_upd = 1; lcc_val = 1;
      tick(); idle();
      chk("R2 R5 loop condition code is bit 1", {28'd0, stat_q}, 32'hB);
      cc_upd = 1; cc_val = 1; lcc_upd = 1; lcc_val = 1;
      sw_wr_en = 1; sup_mode = 0; sw_wr_data = 4'b0000;
      tick(); idle();
      chk("R6 user write beats strobes", {28'd0, stat_q}, 32'h8);
      cc_upd = 1; cc_val = 0;
      sw_wr_en = 1; sup_mode = 1; sw_wr_data = 4'b0111;
      tick(); idle();
      chk("R6 supervisor write beats strobe", {28'd0, stat_q}, 32'h7);
      dbg_wr_en = 1; dbg_wr_data = DB;
      acc(DA, 1'b0);
      chk("R10 same-cycle access uses old address", {31'd0, brk_trap}, 32'd1);
      tick(); idle();
      acc(DB, 1'b0);
      chk("R10 new address active next cycle", {31'd0, brk_trap}, 32'd1);
      acc(DA, 1'b0);
      chk("R10 old address no longer matches", {31'd0, brk_trap}, 32'd0);
      idle();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule